// File: doc/BRIEF.md
# Multi-limb multiply-accumulate unit

This block is a stateful multiply-accumulate engine for multi-precision integer arithmetic. It holds a 128-bit multiplier made of two 64-bit limbs (M1 high, M0 low) and a 128-bit running partial product made of two limbs (P1 high, P0 low). Software-style loops over big numbers feed it one 64-bit limb of the other operand per command. Each multiply returns one finished 64-bit output limb and keeps the upper 128 bits of the sum for the next step.

A multiply command supplies two operands, rs on `cmd_a` and rt on `cmd_b`. The unit forms the 192-bit total rs × (M1:M0) + rt + (P1:P0). It returns the low 64 bits on `res_data` and stores bits 127:64 in P0 and bits 191:128 in P1. The total can never exceed 2^192 − 1, so no carry leaves the top limb.

Load commands set a single limb from `cmd_a`. Loading M0 clears M1, and loading P0 clears P1, so a single-limb value needs only one command. The 64×128 product is built from 64×64 partial products. A parameter selects between two variants: two multipliers that finish in one cycle, or one shared multiplier that finishes in two cycles. Commands use a valid/ready handshake.

Top module: `limb_mac`

## Requirements
- R1: After reset, cmd_ready is 1, res_valid is 0, and M0, M1, P0 and P1 are all zero.
- R2: A multiply (cmd_op 4, rs on cmd_a, rt on cmd_b) returns on res_data the low 64 bits of the 192-bit sum rs × (M1:M0) + rt + (P1:P0).
- R3: After a multiply, P0 holds bits 127:64 and P1 holds bits 191:128 of that sum, with carries carried across every limb. With every operand and limb all-ones, the result, P0 and P1 are all-ones.
- R4: cmd_op 0 loads M0 from cmd_a and clears M1.
- R5: cmd_op 1 loads M1 from cmd_a and leaves M0, P0 and P1 unchanged.
- R6: cmd_op 2 loads P0 from cmd_a and clears P1.
- R7: cmd_op 3 loads P1 from cmd_a and leaves M0, M1 and P0 unchanged.
- R8: Once a multiply is accepted, cmd_ready is 0 for PASSES cycles. res_valid is then high for exactly one cycle, PASSES cycles after the accepting edge, and cmd_ready is 1 in that cycle.
- R9: A load takes effect at its accepting edge. cmd_ready stays 1, res_valid stays 0, and cmd_b has no effect.
- R10: cmd_op values 5, 6 and 7 are accepted and change no limb and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can accept a command this cycle |
| cmd_op | input | 3 | 0 load M0, 1 load M1, 2 load P0, 3 load P1, 4 multiply |
| cmd_a | input | LIMB_W | Load operand, or rs for a multiply |
| cmd_b | input | LIMB_W | rt for a multiply; ignored otherwise |
| res_valid | output | 1 | One-cycle strobe: res_data holds a multiply result |
| res_data | output | LIMB_W | Low limb of the last multiply total |

## Verification
The bound checker checks on every cycle the handshake timing of a multiply: how long ready stays low, that done is a single pulse, and that ready is high with done. It also checks how each load changes the four limbs, including the clearing of M1 and P1, and that idle cycles and unused codes leave the limbs unchanged. The arithmetic itself cannot be checked by a property. It is shown only by the bench scenarios: fixed vectors with expected values worked out by hand, a random command stream compared with a 192-bit reference model, and the all-ones case where the total reaches 2^192 − 1. The state of P is read back through multiplies with zero operands.

// File: rtl/limb_mac_pkg.sv
package limb_mac_pkg;

   // Command codes on cmd_op; codes above CMD_MUL are accepted and ignored.
   typedef enum logic [2:0] {
      CMD_LOAD_M0 = 3'd0,
      CMD_LOAD_M1 = 3'd1,
      CMD_LOAD_P0 = 3'd2,
      CMD_LOAD_P1 = 3'd3,
      CMD_MUL     = 3'd4
   } mac_cmd_e;

   // Number of limbs in the full sum and in the multiplier.
   localparam int unsigned SUM_LIMBS = 3;
   localparam int unsigned MPY_LIMBS = 2;

endpackage

// File: rtl/limb_mac_add.sv
// Multi-limb adder: one carry per limb boundary, carry out of the top limb dropped.
module limb_mac_add #(
   parameter int unsigned W     = 64,
   parameter int unsigned LIMBS = 3
) (
   input  logic [LIMBS*W-1:0] a,
   input  logic [LIMBS*W-1:0] b,
   output logic [LIMBS*W-1:0] sum
);

   logic [LIMBS-1:0] carry;
   assign carry[0] = 1'b0;

   for (genvar i = 0; i < LIMBS; i++) begin : g_limb
      if (i < LIMBS - 1) begin : g_mid
         assign {carry[i+1], sum[i*W +: W]} =
            {1'b0, a[i*W +: W]} + {1'b0, b[i*W +: W]} + {{W{1'b0}}, carry[i]};
      end else begin : g_top
         assign sum[i*W +: W] =
            a[i*W +: W] + b[i*W +: W] + {{(W-1){1'b0}}, carry[i]};
      end
   end

endmodule

// File: rtl/limb_mac_mul.sv
// One limb-by-limb partial product, full double-width result.
module limb_mac_mul #(
   parameter int unsigned W = 64
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [2*W-1:0] p
);

   localparam int unsigned PW = 2 * W;

   assign p = {{W{1'b0}}, a} * {{W{1'b0}}, b};

   initial begin
      if (PW != 2 * W) $fatal(1, "limb_mac_mul: product width mismatch");
   end

endmodule

// File: rtl/limb_mac_ctrl.sv
// Handshake and pass sequencing for the multiply.
module limb_mac_ctrl
   import limb_mac_pkg::*;
#(
   parameter int unsigned PASSES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [2:0] cmd_op,
   output logic       cmd_ready,
   output logic       wr_en,
   output logic       launch,
   output logic       step,
   output logic       phase,
   output logic       commit,
   output logic       done
);

   localparam logic LAST_PH = (PASSES > 1);

   logic busy_q;
   logic phase_q;
   logic done_q;
   logic accept;

   assign cmd_ready = !busy_q;
   assign accept    = cmd_valid && cmd_ready;
   assign launch    = accept && (cmd_op == CMD_MUL);
   assign wr_en     = accept && (cmd_op != CMD_MUL);
   assign step      = busy_q;
   assign phase     = phase_q;
   assign commit    = busy_q && (phase_q == LAST_PH);
   assign done      = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         phase_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= commit;
         if (launch) begin
            busy_q  <= 1'b1;
            phase_q <= 1'b0;
         end else if (commit) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
         end else if (busy_q) begin
            phase_q <= ~phase_q;
         end
      end
   end

endmodule

// File: rtl/limb_mac_core.sv
// Limb state and the 192-bit datapath; PASSES picks parallel or shared multiplier.
module limb_mac_core
   import limb_mac_pkg::*;
#(
   parameter int unsigned W      = 64,
   parameter int unsigned PASSES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [2:0]   wr_op,
   input  logic [W-1:0] wr_data,
   input  logic         launch,
   input  logic [W-1:0] rs_in,
   input  logic [W-1:0] rt_in,
   input  logic         step,
   input  logic         phase,
   input  logic         commit,
   output logic [W-1:0] result
);

   localparam int unsigned D = MPY_LIMBS * W;
   localparam int unsigned S = SUM_LIMBS * W;

   logic [W-1:0] m0_q, m1_q, p0_q, p1_q;
   logic [W-1:0] rs_q, rt_q, res_q;
   logic [S-1:0] base, sum0, total;
   logic [D-1:0] pp_lo;

   // (0 : P1 : P0) + rt, then + rs*M0.
   limb_mac_add #(.W(W), .LIMBS(SUM_LIMBS)) u_add_rt (
      .a   ({{W{1'b0}}, p1_q, p0_q}),
      .b   ({{D{1'b0}}, rt_q}),
      .sum (base)
   );

   limb_mac_add #(.W(W), .LIMBS(SUM_LIMBS)) u_add_lo (
      .a   (base),
      .b   ({{W{1'b0}}, pp_lo}),
      .sum (sum0)
   );

   if (PASSES == 1) begin : g_par
      logic [D-1:0] pp_hi;
      logic [1:0]   unused_ctl;
      assign unused_ctl = {step, phase};

      limb_mac_mul #(.W(W)) u_mul_lo (.a(rs_q), .b(m0_q), .p(pp_lo));
      limb_mac_mul #(.W(W)) u_mul_hi (.a(rs_q), .b(m1_q), .p(pp_hi));

      limb_mac_add #(.W(W), .LIMBS(SUM_LIMBS)) u_add_hi (
         .a   (sum0),
         .b   ({pp_hi, {W{1'b0}}}),
         .sum (total)
      );
   end else begin : g_seq
      logic [W-1:0] mul_b;
      logic [D-1:0] pp;
      logic [S-1:0] acc_q;

      assign mul_b = phase ? m1_q : m0_q;
      assign pp_lo = pp;

      limb_mac_mul #(.W(W)) u_mul (.a(rs_q), .b(mul_b), .p(pp));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc_q <= '0;
         end else if (step && !phase) begin
            acc_q <= sum0;
         end
      end

      limb_mac_add #(.W(W), .LIMBS(SUM_LIMBS)) u_add_hi (
         .a   (acc_q),
         .b   ({pp, {W{1'b0}}}),
         .sum (total)
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m0_q  <= '0;
         m1_q  <= '0;
         p0_q  <= '0;
         p1_q  <= '0;
         rs_q  <= '0;
         rt_q  <= '0;
         res_q <= '0;
      end else begin
         if (launch) begin
            rs_q <= rs_in;
            rt_q <= rt_in;
         end
         if (commit) begin
            res_q <= total[W-1:0];
            p0_q  <= total[D-1:W];
            p1_q  <= total[S-1:D];
         end else if (wr_en) begin
            case (wr_op)
               CMD_LOAD_M0: begin
                  m0_q <= wr_data;
                  m1_q <= '0;
               end
               CMD_LOAD_M1: m1_q <= wr_data;
               CMD_LOAD_P0: begin
                  p0_q <= wr_data;
                  p1_q <= '0;
               end
               CMD_LOAD_P1: p1_q <= wr_data;
               default: ;
            endcase
         end
      end
   end

   assign result = res_q;

endmodule

// File: rtl/limb_mac.sv
// Top: multi-limb multiply-accumulate unit.
module limb_mac #(
   parameter int unsigned LIMB_W = 64,
   parameter int unsigned PASSES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [2:0]        cmd_op,
   input  logic [LIMB_W-1:0] cmd_a,
   input  logic [LIMB_W-1:0] cmd_b,
   output logic              res_valid,
   output logic [LIMB_W-1:0] res_data
);

   initial begin
      if (PASSES != 1 && PASSES != 2) $fatal(1, "limb_mac: PASSES must be 1 or 2");
      if (LIMB_W < 2) $fatal(1, "limb_mac: LIMB_W too small");
   end

   logic wr_en, launch, step, phase, commit;

   limb_mac_ctrl #(.PASSES(PASSES)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_ready (cmd_ready),
      .wr_en     (wr_en),
      .launch    (launch),
      .step      (step),
      .phase     (phase),
      .commit    (commit),
      .done      (res_valid)
   );

   limb_mac_core #(.W(LIMB_W), .PASSES(PASSES)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_op   (cmd_op),
      .wr_data (cmd_a),
      .launch  (launch),
      .rs_in   (cmd_a),
      .rt_in   (cmd_b),
      .step    (step),
      .phase   (phase),
      .commit  (commit),
      .result  (res_data)
   );

endmodule

// File: rtl/limb_mac_chk.sv
// Protocol and limb-state checker, bound into limb_mac.
module limb_mac_chk #(
   parameter int unsigned LIMB_W = 64,
   parameter int unsigned PASSES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [2:0]        cmd_op,
   input logic [LIMB_W-1:0] cmd_a,
   input logic              res_valid,
   input logic [LIMB_W-1:0] m0,
   input logic [LIMB_W-1:0] m1,
   input logic [LIMB_W-1:0] p0,
   input logic [LIMB_W-1:0] p1
);

   localparam int unsigned CW = $clog2(PASSES + 2);
   localparam logic [CW-1:0] WAIT_MAX = CW'(PASSES);

   logic          acc;
   logic [CW-1:0] wait_q;

   assign acc = cmd_valid && cmd_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wait_q <= '0;
      else if (!cmd_ready) wait_q <= wait_q + 1'b1;
      else wait_q <= '0;
   end

   // R8: an accepted multiply drops ready on the next cycle
   a_r8_busy_after_mul: assert property (@(posedge clk) disable iff (!rst_n)
      acc && cmd_op == 3'd4 |=> !cmd_ready);

   // R8: ready never stays low beyond PASSES cycles
   a_r8_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
      wait_q <= WAIT_MAX);

   // R8: done comes with ready high, right after a busy cycle, and lasts one cycle
   a_r8_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> cmd_ready && $past(!cmd_ready));

   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R9: a load keeps ready high and raises no done
   a_r9_load_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
      acc && cmd_op != 3'd4 |=> cmd_ready && !res_valid);

   // R4: load M0 clears M1
   a_r4_m0_clears_m1: assert property (@(posedge clk) disable iff (!rst_n)
      acc && cmd_op == 3'd0 |=> m0 == $past(cmd_a) && m1 == '0 && $stable(p0) && $stable(p1));

   // R5: load M1 touches M1 only
   a_r5_m1_only: assert property (@(posedge clk) disable iff (!rst_n)
      acc && cmd_op == 3'd1 |=> m1 == $past(cmd_a) && $stable(m0) && $stable(p0) && $stable(p1));

   // R6: load P0 clears P1
   a_r6_p0_clears_p1: assert property (@(posedge clk) disable iff (!rst_n)
      acc && cmd_op == 3'd2 |=> p0 == $past(cmd_a) && p1 == '0 && $stable(m0) && $stable(m1));

   // R7: load P1 touches P1 only
   a_r7_p1_only: assert property (@(posedge clk) disable iff (!rst_n)
      acc && cmd_op == 3'd3 |=> p1 == $past(cmd_a) && $stable(p0) && $stable(m0) && $stable(m1));

   // R10: idle cycles and unused codes leave every limb alone
   a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready && !(cmd_valid && cmd_op <= 3'd4) |=>
         $stable(m0) && $stable(m1) && $stable(p0) && $stable(p1));

endmodule

bind limb_mac limb_mac_chk #(.LIMB_W(LIMB_W), .PASSES(PASSES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_op    (cmd_op),
   .cmd_a     (cmd_a),
   .res_valid (res_valid),
   .m0        (u_core.m0_q),
   .m1        (u_core.m1_q),
   .p0        (u_core.p0_q),
   .p1        (u_core.p1_q)
);

// File: tb/limb_mac_bench.sv
`timescale 1ns/1ps
module limb_mac_bench;

   localparam int unsigned W      = 64;
   localparam int unsigned PASSES = 2;

   localparam logic [2:0] OM0 = 3'd0, OM1 = 3'd1, OP0 = 3'd2, OP1 = 3'd3, OMU = 3'd4;
   localparam logic [63:0] ONES = '1;
   localparam logic [63:0] JUNK = 64'hDEAD_BEEF_0BAD_F00D;

   typedef struct packed {
      logic [2:0]  op;
      logic [63:0] a;
      logic [63:0] b;
      logic [63:0] exp;
      logic [7:0]  req;
   } vec_t;

   // Expected results worked out by hand from R1..R10; exp used only for multiplies.
   localparam int NV = 37;
   localparam vec_t VEC [NV] = '{
      '{OMU, 64'd1, 64'd0, 64'd0, 8'd1},        // R1 M0 zero after reset
      '{OMU, 64'd0, 64'd0, 64'd0, 8'd1},        // R1 P zero after reset
      '{OM0, 64'd5, JUNK, 64'd0, 8'd9},         // R9 cmd_b ignored
      '{OMU, 64'd7, 64'd11, 64'd46, 8'd2},      // R2 7*5+11
      '{OMU, 64'd0, 64'd0, 64'd0, 8'd3},        // R3 no upper limbs
      '{OP1, 64'd1, 64'd0, 64'd0, 8'd7},
      '{OP0, 64'd0, JUNK, 64'd0, 8'd6},         // R6 clears P1
      '{OMU, 64'd0, 64'd0, 64'd0, 8'd6},
      '{OMU, 64'd0, 64'd0, 64'd0, 8'd6},
      '{OM1, 64'd3, 64'd0, 64'd0, 8'd5},
      '{OM0, 64'd2, 64'd0, 64'd0, 8'd4},        // R4 clears M1
      '{OMU, 64'd1, 64'd0, 64'd2, 8'd4},
      '{OMU, 64'd0, 64'd0, 64'd0, 8'd4},
      '{OM1, 64'd9, 64'd0, 64'd0, 8'd5},        // R5 M0 kept
      '{OMU, 64'd1, 64'd0, 64'd2, 8'd5},
      '{OMU, 64'd0, 64'd0, 64'd9, 8'd5},
      '{OMU, 64'd0, 64'd0, 64'd0, 8'd5},
      '{OP0, 64'hAAAA, 64'd0, 64'd0, 8'd7},
      '{OP1, 64'h5555, 64'd0, 64'd0, 8'd7},     // R7 P0 kept
      '{OMU, 64'd0, 64'd0, 64'hAAAA, 8'd7},
      '{OMU, 64'd0, 64'd0, 64'h5555, 8'd7},
      '{OMU, 64'd0, 64'd0, 64'd0, 8'd7},
      '{OP0, 64'd7, 64'd0, 64'd0, 8'd10},
      '{3'd5, ONES, ONES, 64'd0, 8'd10},        // R10 unused codes
      '{3'd6, ONES, ONES, 64'd0, 8'd10},
      '{3'd7, ONES, ONES, 64'd0, 8'd10},
      '{OMU, 64'd0, 64'd0, 64'd7, 8'd10},
      '{OMU, 64'd1, 64'd0, 64'd2, 8'd10},
      '{OMU, 64'd0, 64'd0, 64'd9, 8'd10},
      '{OM0, ONES, 64'd0, 64'd0, 8'd3},
      '{OM1, ONES, 64'd0, 64'd0, 8'd3},
      '{OP0, ONES, 64'd0, 64'd0, 8'd3},
      '{OP1, ONES, 64'd0, 64'd0, 8'd3},
      '{OMU, ONES, ONES, ONES, 8'd3},           // R3 total = 2^192-1
      '{OMU, 64'd0, 64'd0, ONES, 8'd3},
      '{OMU, 64'd0, 64'd0, ONES, 8'd3},
      '{OMU, 64'd0, 64'd0, 64'd0, 8'd3}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic [2:0]    cmd_op = '0;
   logic [W-1:0]  cmd_a = '0;
   logic [W-1:0]  cmd_b = '0;
   logic          res_valid;
   logic [W-1:0]  res_data;

   int checks = 0;
   int errors = 0;

   // Reference model state.
   logic [63:0] mm0 = '0, mm1 = '0, mp0 = '0, mp1 = '0;

   always #10 clk = ~clk;

   limb_mac #(.LIMB_W(W), .PASSES(PASSES)) u_limb_mac (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_ready (cmd_ready),
      .cmd_op    (cmd_op),
      .cmd_a     (cmd_a),
      .cmd_b     (cmd_b),
      .res_valid (res_valid),
      .res_data  (res_data)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp, input string what);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic model(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                        output logic [63:0] exp);
      logic [191:0] t;
      exp = '0;
      case (op)
         OM0: begin mm0 = a; mm1 = '0; end
         OM1: mm1 = a;
         OP0: begin mp0 = a; mp1 = '0; end
         OP1: mp1 = a;
         OMU: begin
            t = {128'd0, a} * {64'd0, mm1, mm0} + {128'd0, b} + {64'd0, mp1, mp0};
            exp = t[63:0];
            mp0 = t[127:64];
            mp1 = t[191:128];
         end
         default: ;
      endcase
   endtask

   // Issues one command; checks handshake timing (R8, R9) and returns the result.
   task automatic issue(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                        output logic [63:0] res, output logic [63:0] exp);
      res = '0;
      @(negedge clk);
      chk(cmd_ready && !res_valid, "R8", {62'd0, cmd_ready, res_valid}, 64'd2, "idle before command");
      cmd_valid = 1'b1; cmd_op = op; cmd_a = a; cmd_b = b;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_b = JUNK;
      model(op, a, b, exp);
      if (op == OMU) begin
         chk(!cmd_ready && !res_valid, "R8", {62'd0, cmd_ready, res_valid}, 64'd0, "busy after accept");
         repeat (PASSES - 1) begin
            @(negedge clk);
            chk(!cmd_ready && !res_valid, "R8", {62'd0, cmd_ready, res_valid}, 64'd0, "busy pass");
         end
         @(negedge clk);
         chk(cmd_ready && res_valid, "R8", {62'd0, cmd_ready, res_valid}, 64'd3, "done strobe");
         res = res_data;
      end else begin
         chk(cmd_ready && !res_valid, "R9", {62'd0, cmd_ready, res_valid}, 64'd2, "load no stall");
      end
   endtask

   function automatic logic [63:0] pick(input int k);
      case (k)
         0: return 64'd0;
         1: return ONES;
         default: return {$urandom, $urandom};
      endcase
   endfunction

   initial begin
      logic [63:0] res, exp;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_ready && !res_valid, "R1", {62'd0, cmd_ready, res_valid}, 64'd2, "reset outputs");

      // Table walk: hand-computed expectations.
      for (int i = 0; i < NV; i++) begin
         issue(VEC[i].op, VEC[i].a, VEC[i].b, res, exp);
         if (VEC[i].op == OMU)
            chk(res === VEC[i].exp, $sformatf("R%0d", VEC[i].req), res, VEC[i].exp,
                $sformatf("vector %0d", i));
      end

      // Random command stream against the 192-bit model (R2, R3, R4..R7, R10).
      for (int n = 0; n < 400; n++) begin
         int op_pick;
         logic [2:0] op;
         logic [63:0] a, b;
         op_pick = $urandom_range(0, 10);
         op = (op_pick >= 7) ? OMU : 3'(op_pick);
         a = pick($urandom_range(0, 4));
         b = pick($urandom_range(0, 4));
         issue(op, a, b, res, exp);
         if (op == OMU)
            chk(res === exp, (a == 0 && b == 0) ? "R3" : "R2", res, exp, "random multiply");
      end

      // Reset in mid-run clears all limbs (R1).
      issue(OM0, 64'd5, 64'd0, res, exp);
      issue(OP1, 64'd3, 64'd0, res, exp);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(cmd_ready && !res_valid, "R1", {62'd0, cmd_ready, res_valid}, 64'd2, "mid-run reset outputs");
      rst_n = 1'b1;
      mm0 = '0; mm1 = '0; mp0 = '0; mp1 = '0;
      issue(OMU, 64'd1, 64'd0, res, exp);
      chk(res === 64'd0, "R1", res, 64'd0, "M0 cleared by reset");
      issue(OMU, 64'd0, 64'd0, res, exp);
      chk(res === 64'd0, "R1", res, 64'd0, "P0 cleared by reset");
      issue(OMU, 64'd0, 64'd0, res, exp);
      chk(res === 64'd0, "R1", res, 64'd0, "P1 cleared by reset");
      @(negedge clk);
      chk(!res_valid, "R8", {63'd0, res_valid}, 64'd0, "done is one cycle");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule